// File: doc/BRIEF.md
# Line Switch State Controller

This block turns three mode-select inputs and an alternate-configuration input into enable commands for the switch groups of a telephone line-card access switch. There are four switch groups: the break pair, the ringing-return switch, the ringing switch and the test pair. A small state machine drives the enables from its state register. The states are `ST_ALLOFF`, `ST_TALK`, `ST_RING`, `ST_OTHER` and `ST_DRAIN`. `ST_DRAIN` is the interval in which the ringing switch is still closed but ringing is no longer requested. Because the ringing switch is a zero-crossing device, it opens only on a clock edge where `zc_pulse` is high.

An input hold latch sits in front of the decoder. While `hold_en` is low, the latch passes the select inputs through. While `hold_en` is high, it freezes the select bits captured at the last clock edge on which `hold_en` was low. Two active-low overrides, `dis_n` and `therm_n`, bypass the latch and force an All-Off request. Leaving ringing always follows the same order: the ringing switch opens, at least one edge passes with every switch open, and only then may the break pair close.

Transitions:
- From `ST_ALLOFF`, `ST_TALK` or `ST_OTHER`, the machine moves straight to the state that is requested.
- From `ST_RING`:
  - it stays in `ST_RING` while ringing is requested;
  - otherwise it goes to `ST_ALLOFF` on an edge where the zero-current pulse is present;
  - otherwise it goes to `ST_DRAIN`.
- From `ST_DRAIN`:
  - it returns to `ST_RING` if ringing is requested again;
  - otherwise it goes to `ST_ALLOFF` on a zero-current pulse;
  - otherwise it stays in `ST_DRAIN`.

Top module: `line_switch_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, all four enables are 0 and `state_code` is 2'b00. Reset also loads the hold latch with the All-Off select value (ctl1=1, ctl0=1).
- R2: With `hold_en`=0, select values present at a rising clock edge take effect in the enables and `state_code` after that same edge.
- R3: With `hold_en`=1, the block keeps acting on the select bits captured at the last edge with `hold_en`=0. Changes to ctl0..ctl2 are ignored until `hold_en` returns to 0.
- R4: If `dis_n`=0 or `therm_n`=0 at an edge, then after that edge the break pair and the ringing-return switch are off and `state_code` is 2'b00, whatever the latch holds. The request resumes once both overrides are high.
- R5: With alt_cfg=0, ctl2=0, ctl1=1 and ctl0=0, the block selects Ringing. The ringing-return and ringing switches are on, the break and test pairs are off, and `state_code`=2'b01.
- R6: With alt_cfg=0, ctl2=0, ctl1=0 and ctl0=0, the block selects Talk. The break pair is on, every other group is off, and `state_code`=2'b10.
- R7: ctl1=1 with ctl0=1 selects All-Off for any alt_cfg and ctl2. All groups are off and `state_code`=2'b00.
- R8: Every other combination is undefined. It decodes to all groups off with `state_code`=2'b11.
- R9: Once closed, the ringing switch stays closed until the first edge on which `zc_pulse`=1 and ringing is not requested. It opens at that edge. During the wait, `state_code` is 2'b00 and the ringing-return switch and break pair are off.
- R10: The break pair is never on in the cycle right after a cycle in which the ringing switch is on.
- R11: A ringing request that arrives while the block waits for zero current turns the ringing-return switch back on after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl0 | input | 1 | Mode select bit 0 |
| ctl1 | input | 1 | Mode select bit 1 |
| ctl2 | input | 1 | Mode select bit 2 |
| alt_cfg | input | 1 | Alternate configuration; 0 enables the Ringing and Talk decodes |
| hold_en | input | 1 | 1 freezes the select latch, 0 makes it transparent |
| dis_n | input | 1 | Active-low disable override |
| therm_n | input | 1 | Active-low thermal-shutdown override |
| zc_pulse | input | 1 | Zero-current indication for the ringing switch |
| brk_on | output | 1 | Break pair enable |
| ring_ret_on | output | 1 | Ringing-return switch enable |
| ring_on | output | 1 | Ringing switch enable |
| test_on | output | 1 | Test pair enable |
| state_code | output | 2 | 00 All-Off, 01 Ringing, 10 Talk, 11 Other |

## Verification
A wrong state register is visible at the enables and at `state_code` one edge after the bad transition, because every output is a direct decode of that register. A stale or corrupted hold latch shows up as a mode that ignores the select inputs within one edge of their change. The hardest case to see is a premature exit from `ST_DRAIN`. It is exposed only by holding `zc_pulse` low for several cycles after leaving ringing and checking that `ring_on` stays high and `brk_on` stays low for all of them.

// File: rtl/lss_pkg.sv
package lss_pkg;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_ALLOFF = 3'b011;

    typedef enum logic [1:0] {
        REQ_OFF   = 2'b00,
        REQ_RING  = 2'b01,
        REQ_TALK  = 2'b10,
        REQ_OTHER = 2'b11
    } req_e;

    typedef enum logic [2:0] {
        ST_ALLOFF = 3'd0,
        ST_RING   = 3'd1,
        ST_TALK   = 3'd2,
        ST_OTHER  = 3'd3,
        ST_DRAIN  = 3'd4
    } state_e;

endpackage

// File: rtl/lss_in_latch.sv
module lss_in_latch #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] sel_in,
    output logic [W-1:0] sel_eff
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= RST_VAL;
        else if (!hold)
            held_q <= sel_in;
    end

    always_comb begin
        sel_eff = hold ? held_q : sel_in;
    end

    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(held_q)); // R3

    AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> held_q == $past(sel_in)); // R2

endmodule

// File: rtl/lss_decode.sv
module lss_decode
    import lss_pkg::*;
#(
    parameter int W = SEL_W
) (
    input  logic         alt_cfg,
    input  logic [W-1:0] sel,
    output req_e         req
);

    always_comb begin
        if (sel[1] && sel[0])
            req = REQ_OFF;
        else if (alt_cfg || sel[2])
            req = REQ_OTHER;
        else if (sel[1])
            req = REQ_RING;
        else if (!sel[0])
            req = REQ_TALK;
        else
            req = REQ_OTHER;
    end

endmodule

// File: rtl/lss_fsm.sv
module lss_fsm
    import lss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  req_e       req,
    input  logic       force_off,
    input  logic       zc,
    output logic       brk_on,
    output logic       ring_ret_on,
    output logic       ring_on,
    output logic       test_on,
    output logic [1:0] state_code
);

    state_e state_q, state_d;
    req_e   req_eff;

    function automatic state_e to_state(input req_e r);
        case (r)
            REQ_RING:  return ST_RING;
            REQ_TALK:  return ST_TALK;
            REQ_OTHER: return ST_OTHER;
            default:   return ST_ALLOFF;
        endcase
    endfunction

    always_comb begin
        req_eff = force_off ? REQ_OFF : req;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ALLOFF, ST_TALK, ST_OTHER: state_d = to_state(req_eff);
            ST_RING: begin
                if (req_eff == REQ_RING) state_d = ST_RING;
                else if (zc)             state_d = ST_ALLOFF;
                else                     state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (req_eff == REQ_RING) state_d = ST_RING;
                else if (zc)             state_d = ST_ALLOFF;
                else                     state_d = ST_DRAIN;
            end
            default: state_d = ST_ALLOFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ALLOFF;
        else        state_q <= state_d;
    end

    always_comb begin
        brk_on      = 1'b0;
        ring_ret_on = 1'b0;
        ring_on     = 1'b0;
        test_on     = 1'b0;
        state_code  = REQ_OFF;
        unique case (state_q)
            ST_ALLOFF: state_code = REQ_OFF;
            ST_TALK: begin
                brk_on     = 1'b1;
                state_code = REQ_TALK;
            end
            ST_RING: begin
                ring_ret_on = 1'b1;
                ring_on     = 1'b1;
                state_code  = REQ_RING;
            end
            ST_OTHER: state_code = REQ_OTHER;
            ST_DRAIN: begin
                ring_on    = 1'b1;
                state_code = REQ_OFF;
            end
            default: state_code = REQ_OFF;
        endcase
    end

    AST_FORCE_ALLOFF: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!brk_on && !ring_ret_on)); // R4

    AST_RING_WAITS_ZC: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_on && !zc) |=> ring_on); // R9

    AST_RING_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_on && zc && req_eff != REQ_RING) |=> !ring_on); // R9

    AST_BREAK_AFTER_RING: assert property (@(posedge clk) disable iff (!rst_n)
        ring_on |=> !brk_on); // R10

    AST_RE_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_on && req_eff == REQ_RING) |=> ring_ret_on); // R11

endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
    import lss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl0,
    input  logic       ctl1,
    input  logic       ctl2,
    input  logic       alt_cfg,
    input  logic       hold_en,
    input  logic       dis_n,
    input  logic       therm_n,
    input  logic       zc_pulse,
    output logic       brk_on,
    output logic       ring_ret_on,
    output logic       ring_on,
    output logic       test_on,
    output logic [1:0] state_code
);

    logic [SEL_W-1:0] sel_raw;
    logic [SEL_W-1:0] sel_eff;
    req_e             dec_req;
    logic             force_off;

    always_comb begin
        sel_raw   = {ctl2, ctl1, ctl0};
        force_off = !dis_n || !therm_n;
    end

    lss_in_latch #(
        .W       (SEL_W),
        .RST_VAL (SEL_ALLOFF)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold_en),
        .sel_in  (sel_raw),
        .sel_eff (sel_eff)
    );

    lss_decode #(
        .W (SEL_W)
    ) u_decode (
        .alt_cfg (alt_cfg),
        .sel     (sel_eff),
        .req     (dec_req)
    );

    lss_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (dec_req),
        .force_off   (force_off),
        .zc          (zc_pulse),
        .brk_on      (brk_on),
        .ring_ret_on (ring_ret_on),
        .ring_on     (ring_on),
        .test_on     (test_on),
        .state_code  (state_code)
    );

endmodule

// File: tb/line_switch_ctrl_tb_top.sv
module line_switch_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl0 = 1'b1, ctl1 = 1'b1, ctl2 = 1'b0, alt_cfg = 1'b0;
    logic hold_en = 1'b0, dis_n = 1'b1, therm_n = 1'b1, zc_pulse = 1'b0;
    logic brk_on, ring_ret_on, ring_on, test_on;
    logic [1:0] state_code;

    int n_chk = 0;
    int n_fail = 0;
    int bmm_viol = 0;
    logic prev_ring = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_switch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ctl0(ctl0), .ctl1(ctl1), .ctl2(ctl2),
        .alt_cfg(alt_cfg), .hold_en(hold_en), .dis_n(dis_n), .therm_n(therm_n),
        .zc_pulse(zc_pulse), .brk_on(brk_on), .ring_ret_on(ring_ret_on),
        .ring_on(ring_on), .test_on(test_on), .state_code(state_code)
    );

    // Output vector {brk, ret, ring, test, code}
    localparam logic [5:0] E_OFF   = 6'b0000_00;
    localparam logic [5:0] E_RING  = 6'b0110_01;
    localparam logic [5:0] E_TALK  = 6'b1000_10;
    localparam logic [5:0] E_OTHER = 6'b0000_11;
    localparam logic [5:0] E_DRAIN = 6'b0010_00;

    function automatic logic [5:0] expect_of(input logic c, input logic s2,
                                             input logic s1, input logic s0);
        if (s1 && s0)      return E_OFF;    // R7
        if (c || s2)       return E_OTHER;  // R8
        if (s1)            return E_RING;   // R5
        if (s0)            return E_OTHER;  // R8
        return E_TALK;                      // R6
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [5:0] exp);
        logic [5:0] act;
        act = {brk_on, ring_ret_on, ring_on, test_on, state_code};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic set_sel(input logic c, input logic s2, input logic s1, input logic s0);
        alt_cfg = c; ctl2 = s2; ctl1 = s1; ctl0 = s0;
    endtask

    // break-before-make monitor (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ring && brk_on) bmm_viol++;
            prev_ring = ring_on;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R1 in reset", E_OFF);
        rst_n = 1'b1;
        chk("R1 after release", E_OFF);

        // R2: transparent path, one edge
        set_sel(0, 0, 0, 0);
        step(1);
        chk("R2 talk after one edge", E_TALK);
        set_sel(0, 0, 1, 1);
        step(1);
        chk("R2 all-off after one edge", E_OFF);

        // R5..R8 exhaustive sweep, zero-current present so ringing exits in one edge
        zc_pulse = 1'b1;
        for (int v = 0; v < 16; v++) begin
            set_sel(v[3], v[2], v[1], v[0]);
            step(3);
            chk($sformatf("R5/R6/R7/R8 sweep code %0d", v), expect_of(v[3], v[2], v[1], v[0]));
        end

        // R4: overrides across every select combination
        for (int v = 0; v < 16; v++) begin
            set_sel(v[3], v[2], v[1], v[0]);
            dis_n = v[0]; therm_n = ~v[0];
            step(3);
            chk($sformatf("R4 override code %0d", v), E_OFF);
        end
        dis_n = 1'b1; therm_n = 1'b1;
        zc_pulse = 1'b0;
        set_sel(0, 0, 1, 1);
        step(2);

        // R3: hold latch
        set_sel(0, 0, 0, 0);
        step(1);
        hold_en = 1'b1;
        set_sel(0, 0, 1, 0);
        step(3);
        chk("R3 held talk ignores ring select", E_TALK);
        set_sel(0, 0, 1, 1);
        step(2);
        chk("R3 held talk ignores all-off select", E_TALK);
        // R4 bypasses the latch
        dis_n = 1'b0;
        step(1);
        chk("R4 disable overrides held talk", E_OFF);
        dis_n = 1'b1;
        step(1);
        chk("R4 held talk resumes", E_TALK);
        therm_n = 1'b0;
        step(1);
        chk("R4 thermal overrides held talk", E_OFF);
        therm_n = 1'b1;
        hold_en = 1'b0;
        step(1);
        chk("R3 release follows live all-off", E_OFF);

        // R9 / R10: ringing exit waits for zero current
        set_sel(0, 0, 1, 0);
        step(1);
        chk("R5 ring entered", E_RING);
        set_sel(0, 0, 0, 0);
        step(1);
        chk("R9 drain after talk request", E_DRAIN);
        step(5);
        chk("R9 still draining without zero current", E_DRAIN);
        zc_pulse = 1'b1;
        step(1);
        zc_pulse = 1'b0;
        chk("R10 ring opened, break still open", E_OFF);
        step(1);
        chk("R10 break closes after gap", E_TALK);

        // R11: re-ring during drain
        set_sel(0, 0, 1, 0);
        step(1);
        set_sel(0, 0, 1, 1);
        step(1);
        chk("R9 drain after all-off request", E_DRAIN);
        set_sel(0, 0, 1, 0);
        step(1);
        chk("R11 re-ring during drain", E_RING);

        // R4 + R9: disable during ringing
        dis_n = 1'b0;
        step(1);
        chk("R4 disable opens return, ring waits", E_DRAIN);
        step(3);
        chk("R9 ring held under disable", E_DRAIN);
        zc_pulse = 1'b1;
        step(1);
        zc_pulse = 1'b0;
        chk("R9 ring opens on zero current", E_OFF);
        dis_n = 1'b1;
        step(1);
        chk("R4 ring resumes after disable", E_RING);

        // R1: reset mid-operation, latch reloads all-off
        rst_n = 1'b0;
        hold_en = 1'b1;
        step(1);
        chk("R1 reset mid-ring", E_OFF);
        rst_n = 1'b1;
        step(2);
        chk("R1 latch reset value all-off", E_OFF);
        hold_en = 1'b0;
        step(1);

        n_chk++;
        if (bmm_viol != 0) begin
            n_fail++;
            $display("FAIL R10: actual %0d violations expected 0", bmm_viol);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule